// File: doc/BRIEF.md
# Latched-Upper Program Counter

This block holds the 21-bit byte-addressed fetch address of a small 8-bit processor core. Software sees the counter through an 8-bit register window with three slots: the low byte of the counter itself, and two holding latches that stage values for bits 15:8 and bits 20:16. The upper parts of the counter cannot be reached directly. They change only when the low byte is written, at which point both latches are copied into the counter in the same cycle. Reading the low byte works the other way and copies the current upper parts back into the latches, so software can compute an offset and jump to it.

Alongside the register window, the core drives a sequential-advance strobe that steps the counter by one instruction word (two bytes). It also drives a direct-load port for branch, call and goto targets and a return-load port carrying an address popped from the return stack. Neither load port uses or disturbs the latches. Bit 0 of the counter is held at zero so that fetches stay word aligned.

Top module: `pc_latched_upper`

## Requirements
- R1: After reset the counter reads 0 and both latches read 0.
- R2: An advance strobe with no higher-priority load adds 2 to the counter, wrapping modulo 2^21, visible on `fetch_addr_o` after the next clock edge.
- R3: A register write with `reg_sel_i` = 2'b00 (low byte) sets counter bits 7:1 from write-data bits 7:1, bits 15:8 from the middle latch and bits 20:16 from the upper latch, all at the same edge.
- R4: Counter bit 0 is always 0, whatever bit 0 of write data or of a load target.
- R5: With `reg_sel_i` = 2'b00, `reg_rdata_o` shows counter bits 7:0; a read strobe on that slot copies counter bits 15:8 into the middle latch and bits 20:16 into the upper latch at the edge.
- R6: Slot 2'b01 is the 8-bit middle latch and slot 2'b10 the 5-bit upper latch (read data bits 7:5 are zero); both are readable and writable, writing them does not change the counter, and slot 2'b11 reads 0 and ignores writes.
- R7: A direct load writes the full target (bit 0 cleared) into the counter and leaves both latches unchanged.
- R8: A return load writes the return address (bit 0 cleared) into the counter and leaves both latches unchanged; a direct load takes precedence over a return load.
- R9: Counter priority per cycle is direct load, then return load, then low-byte write, then advance; a losing low-byte write or advance has no effect on the counter.
- R10: When write and read strobes are both active in one cycle, the read side effect (latch snapshot) is suppressed and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adv_i | input | 1 | Sequential advance strobe (+2) |
| jmp_en_i | input | 1 | Direct load strobe for branch, call or goto target |
| jmp_addr_i | input | 21 | Direct load target |
| ret_en_i | input | 1 | Return load strobe |
| ret_addr_i | input | 21 | Return address from the stack |
| reg_wr_i | input | 1 | Register window write strobe |
| reg_rd_i | input | 1 | Register window read strobe |
| reg_sel_i | input | 2 | Slot select: 00 low byte, 01 middle latch, 10 upper latch, 11 unused |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected slot |
| fetch_addr_o | output | 21 | Current fetch address |

## Verification
The hardest state to reach from the ports is a latch pair that differs from the counter's upper bits while the low byte is then written, because every route into the latches either copies from the counter or must be staged slot by slot. The stimulus therefore sweeps all 256 byte values through both latches and then writes the low byte, and separately loads scattered targets through the direct and return ports, snapshots them by reading the low byte and reads the latches back. Conflicting strobes in one cycle (load against low write against advance, and read against write) are driven on purpose to pin down priority.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  typedef enum logic [1:0] {
    SLOT_LOW  = 2'b00,
    SLOT_MID  = 2'b01,
    SLOT_UP   = 2'b10,
    SLOT_NONE = 2'b11
  } pcl_slot_e;

  typedef enum logic [1:0] {
    NXT_HOLD   = 2'b00,
    NXT_STEP   = 2'b01,
    NXT_LOWWR  = 2'b10,
    NXT_TARGET = 2'b11
  } pcl_nxt_e;

endpackage

// File: rtl/pcl_rst_sync.sv
module pcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/pcl_reg_port.sv
module pcl_reg_port
  import pcl_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8,
  parameter int MID_W  = 8,
  parameter int UP_W   = 5
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        sel_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [UP_W-1:0]   up_i,
  output logic              low_wr_o,
  output logic              mid_wr_o,
  output logic              up_wr_o,
  output logic              snap_o,
  output logic [BYTE_W-1:0] rdata_o
);

  localparam int UP_PAD = BYTE_W - UP_W;

  pcl_slot_e slot;

  always_comb begin
    slot     = pcl_slot_e'(sel_i);
    low_wr_o = wr_i && (slot == SLOT_LOW);
    mid_wr_o = wr_i && (slot == SLOT_MID);
    up_wr_o  = wr_i && (slot == SLOT_UP);
    snap_o   = rd_i && !wr_i && (slot == SLOT_LOW);
  end

  always_comb begin
    unique case (slot)
      SLOT_LOW:  rdata_o = pc_i[BYTE_W-1:0];
      SLOT_MID:  rdata_o = mid_i;
      SLOT_UP:   rdata_o = {{UP_PAD{1'b0}}, up_i};
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/pcl_latch_bank.sv
module pcl_latch_bank #(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8,
  parameter int MID_W  = 8,
  parameter int UP_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              mid_wr_i,
  input  logic              up_wr_i,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [MID_W-1:0]  mid_o,
  output logic [UP_W-1:0]   up_o
);

  localparam int MID_LSB = BYTE_W;
  localparam int UP_LSB  = BYTE_W + MID_W;

  logic [MID_W-1:0] mid_q, mid_d;
  logic [UP_W-1:0]  up_q, up_d;
  logic             mid_en, up_en;

  always_comb begin
    mid_en = mid_wr_i || snap_i;
    up_en  = up_wr_i  || snap_i;
    mid_d  = snap_i ? pc_i[MID_LSB +: MID_W] : wdata_i[MID_W-1:0];
    up_d   = snap_i ? pc_i[UP_LSB +: UP_W]   : wdata_i[UP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mid_q <= '0;
    end else if (mid_en) begin
      mid_q <= mid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      up_q <= '0;
    end else if (up_en) begin
      up_q <= up_d;
    end
  end

  assign mid_o = mid_q;
  assign up_o  = up_q;

endmodule

// File: rtl/pcl_counter_core.sv
module pcl_counter_core
  import pcl_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8,
  parameter int MID_W  = 8,
  parameter int UP_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              adv_i,
  input  logic              jmp_en_i,
  input  logic [PC_W-1:0]   jmp_addr_i,
  input  logic              ret_en_i,
  input  logic [PC_W-1:0]   ret_addr_i,
  input  logic              low_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [UP_W-1:0]   up_i,
  output logic [PC_W-1:0]   pc_o
);

  localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(1);
  localparam logic [PC_W-1:0] STEP       = PC_W'(2);

  logic [PC_W-1:0] pc_q, pc_d, target;
  pcl_nxt_e        nxt;
  logic            pc_en;

  // priority select: direct > return > low write > advance
  always_comb begin
    target = jmp_en_i ? jmp_addr_i : ret_addr_i;
    if (jmp_en_i || ret_en_i) begin
      nxt = NXT_TARGET;
    end else if (low_wr_i) begin
      nxt = NXT_LOWWR;
    end else if (adv_i) begin
      nxt = NXT_STEP;
    end else begin
      nxt = NXT_HOLD;
    end
  end

  always_comb begin
    pc_en = (nxt != NXT_HOLD);
    unique case (nxt)
      NXT_TARGET: pc_d = target & ALIGN_MASK;
      NXT_LOWWR:  pc_d = {up_i, mid_i, wdata_i} & ALIGN_MASK;
      NXT_STEP:   pc_d = (pc_q + STEP) & ALIGN_MASK;
      default:    pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/pc_latched_upper.sv
module pc_latched_upper #(
  parameter int PC_W        = 21,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              adv_i,
  input  logic              jmp_en_i,
  input  logic [PC_W-1:0]   jmp_addr_i,
  input  logic              ret_en_i,
  input  logic [PC_W-1:0]   ret_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic [PC_W-1:0]   fetch_addr_o
);

  localparam int MID_W = BYTE_W;
  localparam int UP_W  = PC_W - BYTE_W - MID_W;

  logic             rst_sync_n;
  logic [PC_W-1:0]  pc_q;
  logic [MID_W-1:0] mid_q;
  logic [UP_W-1:0]  up_q;
  logic             low_wr, mid_wr, up_wr, snap;

  pcl_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  pcl_reg_port #(
    .PC_W(PC_W), .BYTE_W(BYTE_W), .MID_W(MID_W), .UP_W(UP_W)
  ) i_reg_port (
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .sel_i    (reg_sel_i),
    .pc_i     (pc_q),
    .mid_i    (mid_q),
    .up_i     (up_q),
    .low_wr_o (low_wr),
    .mid_wr_o (mid_wr),
    .up_wr_o  (up_wr),
    .snap_o   (snap),
    .rdata_o  (reg_rdata_o)
  );

  pcl_latch_bank #(
    .PC_W(PC_W), .BYTE_W(BYTE_W), .MID_W(MID_W), .UP_W(UP_W)
  ) i_latch_bank (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .mid_wr_i (mid_wr),
    .up_wr_i  (up_wr),
    .snap_i   (snap),
    .wdata_i  (reg_wdata_i),
    .pc_i     (pc_q),
    .mid_o    (mid_q),
    .up_o     (up_q)
  );

  pcl_counter_core #(
    .PC_W(PC_W), .BYTE_W(BYTE_W), .MID_W(MID_W), .UP_W(UP_W)
  ) i_counter_core (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .adv_i      (adv_i),
    .jmp_en_i   (jmp_en_i),
    .jmp_addr_i (jmp_addr_i),
    .ret_en_i   (ret_en_i),
    .ret_addr_i (ret_addr_i),
    .low_wr_i   (low_wr),
    .wdata_i    (reg_wdata_i),
    .mid_i      (mid_q),
    .up_i       (up_q),
    .pc_o       (pc_q)
  );

  assign fetch_addr_o = pc_q;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8,
  parameter int MID_W  = 8,
  parameter int UP_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              jmp_en,
  input logic [PC_W-1:0]   jmp_addr,
  input logic              ret_en,
  input logic [PC_W-1:0]   ret_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [1:0]        reg_sel,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic [PC_W-1:0]   fetch,
  input logic [MID_W-1:0]  mid_q,
  input logic [UP_W-1:0]   up_q
);

  localparam logic [PC_W-1:0] AMASK = ~PC_W'(1);
  localparam int MID_LSB = BYTE_W;
  localparam int UP_LSB  = BYTE_W + MID_W;

  logic low_wr_c, low_rd_c, load_c;
  assign low_wr_c = reg_wr && (reg_sel == 2'b00);
  assign low_rd_c = reg_rd && !reg_wr && (reg_sel == 2'b00);
  assign load_c   = jmp_en || ret_en;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load_c && !low_wr_c |=> fetch == (($past(fetch) + PC_W'(2)) & AMASK));

  assert_lowwr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_wr_c && !load_c |=>
      fetch == ({$past(up_q), $past(mid_q), $past(reg_wdata)} & AMASK));

  assert_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch[0] == 1'b0);

  assert_snap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd_c |=> mid_q == $past(fetch[MID_LSB +: MID_W]) &&
                 up_q  == $past(fetch[UP_LSB +: UP_W]));

  assert_uppad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'b10 |-> reg_rdata[BYTE_W-1:UP_W] == '0);

  assert_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_en |=> fetch == ($past(jmp_addr) & AMASK));

  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_en && ret_en |=> fetch == ($past(ret_addr) & AMASK));

  assert_keep_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_c && !reg_wr && !reg_rd |=> $stable(mid_q) && $stable(up_q));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !load_c && !low_wr_c |=> $stable(fetch));

  assert_rdwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_rd && reg_sel == 2'b00 |=> $stable(mid_q) && $stable(up_q));

endmodule

bind pc_latched_upper pcl_checker #(
  .PC_W(PC_W), .BYTE_W(BYTE_W), .MID_W(MID_W), .UP_W(UP_W)
) i_pcl_checker (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .adv       (adv_i),
  .jmp_en    (jmp_en_i),
  .jmp_addr  (jmp_addr_i),
  .ret_en    (ret_en_i),
  .ret_addr  (ret_addr_i),
  .reg_wr    (reg_wr_i),
  .reg_rd    (reg_rd_i),
  .reg_sel   (reg_sel_i),
  .reg_wdata (reg_wdata_i),
  .reg_rdata (reg_rdata_o),
  .fetch     (fetch_addr_o),
  .mid_q     (mid_q),
  .up_q      (up_q)
);

// File: tb/test_pc_latched_upper.sv
module test_pc_latched_upper;

  localparam int  PC_W    = 21;
  localparam int  BYTE_W  = 8;
  localparam time CLK_PER = 10ns;
  localparam int  MAXCYC  = 200000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              adv, jmp_en, ret_en, reg_wr, reg_rd;
  logic [PC_W-1:0]   jmp_addr, ret_addr;
  logic [1:0]        reg_sel;
  logic [BYTE_W-1:0] reg_wdata, reg_rdata;
  logic [PC_W-1:0]   fetch;

  int n_cmp = 0;
  int n_bad = 0;

  logic [PC_W-1:0] m_pc;
  logic [7:0]      m_mid;
  logic [4:0]      m_up;

  always #(CLK_PER/2) clk = ~clk;

  pc_latched_upper i_pc_latched_upper (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .adv_i        (adv),
    .jmp_en_i     (jmp_en),
    .jmp_addr_i   (jmp_addr),
    .ret_en_i     (ret_en),
    .ret_addr_i   (ret_addr),
    .reg_wr_i     (reg_wr),
    .reg_rd_i     (reg_rd),
    .reg_sel_i    (reg_sel),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .fetch_addr_o (fetch)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] s);
    case (s)
      2'b00:   return m_pc[7:0];
      2'b01:   return m_mid;
      2'b10:   return {3'b000, m_up};
      default: return 8'h00;
    endcase
  endfunction

  // one cycle of stimulus; checks read data before the edge and counter after it
  task automatic cyc(input string tag, input logic a, input logic j, input logic [PC_W-1:0] ja,
                     input logic r, input logic [PC_W-1:0] ra, input logic w, input logic rd,
                     input logic [1:0] s, input logic [7:0] wd);
    logic [PC_W-1:0] n_pc;
    logic [7:0]      n_mid;
    logic [4:0]      n_up;
    @(negedge clk);
    adv = a; jmp_en = j; jmp_addr = ja; ret_en = r; ret_addr = ra;
    reg_wr = w; reg_rd = rd; reg_sel = s; reg_wdata = wd;
    #1;
    check({tag, " rdata"}, {24'h0, reg_rdata}, {24'h0, exp_rd(s)});
    n_pc = m_pc; n_mid = m_mid; n_up = m_up;
    if (j)                     n_pc = ja & ~PC_W'(1);
    else if (r)                n_pc = ra & ~PC_W'(1);
    else if (w && s == 2'b00)  n_pc = {m_up, m_mid, wd[7:1], 1'b0};
    else if (a)                n_pc = PC_W'((32'(m_pc) + 2) % (1 << PC_W));
    if (w && s == 2'b01) n_mid = wd;
    if (w && s == 2'b10) n_up  = wd[4:0];
    if (rd && !w && s == 2'b00) begin
      n_mid = m_pc[15:8];
      n_up  = m_pc[20:16];
    end
    @(posedge clk);
    #1;
    m_pc = n_pc; m_mid = n_mid; m_up = n_up;
    check({tag, " fetch"}, {11'h0, fetch}, {11'h0, m_pc});
  endtask

  task automatic idle_rd(input string tag, input logic [1:0] s);
    cyc(tag, 0, 0, '0, 0, '0, 0, 0, s, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    adv = 0; jmp_en = 0; ret_en = 0; reg_wr = 0; reg_rd = 0;
    jmp_addr = '0; ret_addr = '0; reg_sel = 2'b00; reg_wdata = '0;
    m_pc = '0; m_mid = '0; m_up = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    check("R1 fetch", {11'h0, fetch}, 32'h0);
    idle_rd("R1 mid", 2'b01);
    idle_rd("R1 up", 2'b10);
    idle_rd("R1 low", 2'b00);

    // R6 / R3 / R4: sweep every byte value through both latches, then write low
    for (int v = 0; v < 256; v++) begin
      cyc("R6 midwr", 0, 0, '0, 0, '0, 1, 0, 2'b01, 8'(v));
      cyc("R6 upwr", 0, 0, '0, 0, '0, 1, 0, 2'b10, 8'(255 - v));
      idle_rd("R6 uprd", 2'b10);
      cyc("R3 lowwr R4", 0, 0, '0, 0, '0, 1, 0, 2'b00, 8'(v ^ 8'h5B));
      idle_rd("R3 lowrd", 2'b00);
    end

    // R6: unused slot reads zero and ignores writes
    cyc("R6 none wr", 0, 0, '0, 0, '0, 1, 0, 2'b11, 8'hFF);
    idle_rd("R6 mid after none", 2'b01);
    idle_rd("R6 up after none", 2'b10);

    // R7 + R2: direct load near the top, advance across the wrap
    cyc("R7 jmp R4", 0, 1, 21'h1FFFF1, 0, '0, 0, 0, 2'b01, 8'h00);
    for (int k = 0; k < 12; k++) cyc("R2 step", 1, 0, '0, 0, '0, 0, 0, 2'b00, 8'h00);
    idle_rd("R7 mid kept", 2'b01);
    idle_rd("R7 up kept", 2'b10);

    // R5 / R8: scattered loads, snapshot by reading low, read latches back
    for (int i = 0; i < 64; i++) begin
      logic [PC_W-1:0] t;
      t = PC_W'((i * 32'h0008_421F) ^ (i << 15));
      if (i[0]) cyc("R7 jmp", 0, 1, t, 0, '0, 0, 0, 2'b00, 8'h00);
      else      cyc("R8 ret", 0, 0, '0, 1, t, 0, 0, 2'b00, 8'h00);
      idle_rd("R8 mid kept", 2'b01);
      cyc("R5 snap", 0, 0, '0, 0, '0, 0, 1, 2'b00, 8'h00);
      idle_rd("R5 mid", 2'b01);
      idle_rd("R5 up", 2'b10);
      cyc("R5 step", 1, 0, '0, 0, '0, 0, 0, 2'b00, 8'h00);
      cyc("R3 relow", 0, 0, '0, 0, '0, 1, 0, 2'b00, 8'(i * 7));
    end

    // R9: priority
    cyc("R9 mid", 0, 0, '0, 0, '0, 1, 0, 2'b01, 8'hA5);
    cyc("R9 all", 1, 1, 21'h0ABCDE, 1, 21'h155555, 1, 0, 2'b00, 8'h33);
    cyc("R9 ret>wr", 1, 0, '0, 1, 21'h012345, 1, 0, 2'b00, 8'h77);
    cyc("R9 wr>adv", 1, 0, '0, 0, '0, 1, 0, 2'b00, 8'h11);
    cyc("R8 j>r", 0, 1, 21'h100003, 1, 21'h0FFFFF, 0, 0, 2'b10, 8'h00);
    idle_rd("R9 mid chk", 2'b01);

    // R10: read and write of the low byte together
    cyc("R10 rdwr", 0, 0, '0, 0, '0, 1, 1, 2'b00, 8'hC4);
    idle_rd("R10 mid", 2'b01);
    idle_rd("R10 up", 2'b10);
    cyc("R10 rdwr mid", 0, 0, '0, 0, '0, 1, 1, 2'b01, 8'h3C);
    idle_rd("R10 mid2", 2'b01);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (MAXCYC) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule